// File: doc/BRIEF.md
# I/O function decoder with current-device routing

This block sits between a processor's two-byte port instructions and a set of attached peripheral devices. Each port instruction raises an input strobe or an output strobe together with an 8-bit function code and the current accumulator value. The second byte is not a device address. It names a function. A few function codes are handled inside the block. Input code 02 returns the interrupt status. Input codes 03 and 04 return two banks of fixed switches. Output code 00 resets every attached device. Output code 01 loads a current-device number from the accumulator.

Every other function code is passed on to the peripherals as a one-cycle device strobe. The strobe carries the function code and the accumulator byte. A select line goes high only for the device whose address equals the stored current-device number. Device `i` answers to address `i`. Each device presents its read byte continuously. On an input of a device function, the block captures the byte of the selected device. If no device is selected, it captures 0xFF.

Everything is registered. Results and strobes appear one clock after the instruction strobe. The read byte holds until the next input function.

Top module: `iofn_selector`

## Requirements
- R1: After reset, rd_data, cur_dev, dev_sel, dev_func and dev_wdata are 0, and init_pulse, dev_rd_stb and dev_wr_stb are low.
- R2: An input strobe with function code 0x02 loads rd_data with irq_status one clock later.
- R3: An input strobe with function code 0x03 loads rd_data with sw_bank_a. Code 0x04 loads it with sw_bank_b. Both take effect one clock later.
- R4: An output strobe with function code 0x00 raises init_pulse for exactly one clock, starting one clock later. In that same clock cur_dev reads 0.
- R5: An output strobe with function code 0x01 sets cur_dev to acc_in one clock later.
- R6: An output strobe with a function code of 0x05 or above produces the following one clock later: a one-clock dev_wr_stb, dev_func equal to the code, and dev_wdata equal to acc_in. At most one dev_sel bit is high, and it is bit i exactly when cur_dev equals i.
- R7: An input strobe with a function code of 0x05 or above produces a one-clock dev_rd_stb with dev_sel formed as in R6. It also loads rd_data with the dev_rdata byte i (bits 8i+7..8i) of the selected device, or with 0xFF when cur_dev matches no device.
- R8: Function codes 0x00 to 0x04 never raise dev_rd_stb, dev_wr_stb or any dev_sel bit.
- R9: An input strobe with function code 0x00 or 0x01 loads rd_data with 0xFF.
- R10: When both strobes arrive in the same clock, only the output function is carried out. rd_data is unchanged.
- R11: In a clock without any strobe, the device strobes and dev_sel are low one clock later, and rd_data and cur_dev hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_rd_stb | input | 1 | One-clock strobe of an input port instruction |
| io_wr_stb | input | 1 | One-clock strobe of an output port instruction |
| func_code | input | DATA_W | Function code, the second instruction byte |
| acc_in | input | DATA_W | Accumulator value at the strobe |
| irq_status | input | DATA_W | Interrupt status byte |
| sw_bank_a | input | DATA_W | First fixed switch bank |
| sw_bank_b | input | DATA_W | Second fixed switch bank |
| dev_rdata | input | NUM_DEV*DATA_W | Read bytes of all devices, device i in bits 8i+7..8i |
| rd_data | output | DATA_W | Byte returned to the accumulator |
| init_pulse | output | 1 | One-clock initialise pulse to all devices |
| cur_dev | output | DATA_W | Latched current-device number |
| dev_sel | output | NUM_DEV | Per-device select qualifier |
| dev_rd_stb | output | 1 | Device input function strobe |
| dev_wr_stb | output | 1 | Device output function strobe |
| dev_func | output | DATA_W | Function code forwarded to devices |
| dev_wdata | output | DATA_W | Accumulator byte forwarded to devices |

## Verification
The hardest case to reach from the ports is a device read with no device selected. To get there, the stimulus must first store a current-device number that lies beyond the attached devices, using output code 01 with an out-of-range accumulator value. Only then does the 0xFF fill become visible. Routing to each device likewise needs a code-01 write before every generic function. The stimulus table therefore interleaves device-number writes with reads and writes, so that each select bit and the fill case are shown in turn. Same-clock read and write strobes are forced with a directed test, as is the clearing of a nonzero device number by the initialise function.

// File: rtl/iofn_pkg.sv
package iofn_pkg;

    typedef enum logic [2:0] {
        FK_INIT   = 3'd0,
        FK_SETDEV = 3'd1,
        FK_IRQ    = 3'd2,
        FK_SWA    = 3'd3,
        FK_SWB    = 3'd4,
        FK_DEVICE = 3'd5
    } fn_kind_e;

    localparam int unsigned CODE_INIT   = 0;
    localparam int unsigned CODE_SETDEV = 1;
    localparam int unsigned CODE_IRQ    = 2;
    localparam int unsigned CODE_SWA    = 3;
    localparam int unsigned CODE_SWB    = 4;

endpackage

// File: rtl/iofn_decode.sv
module iofn_decode
    import iofn_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] func_code,
    output fn_kind_e          kind
);

    always_comb begin
        if (func_code == DATA_W'(CODE_INIT))        kind = FK_INIT;
        else if (func_code == DATA_W'(CODE_SETDEV)) kind = FK_SETDEV;
        else if (func_code == DATA_W'(CODE_IRQ))    kind = FK_IRQ;
        else if (func_code == DATA_W'(CODE_SWA))    kind = FK_SWA;
        else if (func_code == DATA_W'(CODE_SWB))    kind = FK_SWB;
        else                                        kind = FK_DEVICE;
    end

endmodule

// File: rtl/iofn_devsel.sv
module iofn_devsel #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_DEV = 4
) (
    input  logic [DATA_W-1:0]         cur_dev,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata,
    output logic [NUM_DEV-1:0]        hit,
    output logic                      any_hit,
    output logic [DATA_W-1:0]         sel_rdata
);

    logic [DATA_W-1:0] masked [NUM_DEV];

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign hit[i]    = (cur_dev == DATA_W'(i));
        assign masked[i] = hit[i] ? dev_rdata[i*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            sel_rdata = sel_rdata | masked[i];
        end
    end

    assign any_hit = |hit;

endmodule

// File: rtl/iofn_selector.sv
module iofn_selector
    import iofn_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_DEV = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_rd_stb,
    input  logic                      io_wr_stb,
    input  logic [DATA_W-1:0]         func_code,
    input  logic [DATA_W-1:0]         acc_in,
    input  logic [DATA_W-1:0]         irq_status,
    input  logic [DATA_W-1:0]         sw_bank_a,
    input  logic [DATA_W-1:0]         sw_bank_b,
    input  logic [NUM_DEV*DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      init_pulse,
    output logic [DATA_W-1:0]         cur_dev,
    output logic [NUM_DEV-1:0]        dev_sel,
    output logic                      dev_rd_stb,
    output logic                      dev_wr_stb,
    output logic [DATA_W-1:0]         dev_func,
    output logic [DATA_W-1:0]         dev_wdata
);

    localparam logic [DATA_W-1:0] FILL = '1;

    typedef struct packed {
        logic [DATA_W-1:0]  rd_data;
        logic [DATA_W-1:0]  cur_dev;
        logic               init;
        logic [NUM_DEV-1:0] sel;
        logic               rd_stb;
        logic               wr_stb;
        logic [DATA_W-1:0]  func;
        logic [DATA_W-1:0]  wdata;
    } state_t;

    state_t   st_d, st_q;
    fn_kind_e kind;

    logic [NUM_DEV-1:0] hit;
    logic               any_hit;
    logic [DATA_W-1:0]  sel_rdata;

    iofn_decode #(.DATA_W(DATA_W)) u_decode (
        .func_code (func_code),
        .kind      (kind)
    );

    iofn_devsel #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV)) u_devsel (
        .cur_dev   (st_q.cur_dev),
        .dev_rdata (dev_rdata),
        .hit       (hit),
        .any_hit   (any_hit),
        .sel_rdata (sel_rdata)
    );

    always_comb begin
        st_d        = st_q;
        st_d.init   = 1'b0;
        st_d.sel    = '0;
        st_d.rd_stb = 1'b0;
        st_d.wr_stb = 1'b0;
        if (io_wr_stb) begin
            unique case (kind)
                FK_INIT: begin
                    st_d.init    = 1'b1;
                    st_d.cur_dev = '0;
                end
                FK_SETDEV: st_d.cur_dev = acc_in;
                FK_DEVICE: begin
                    st_d.wr_stb = 1'b1;
                    st_d.sel    = hit;
                    st_d.func   = func_code;
                    st_d.wdata  = acc_in;
                end
                default: ;
            endcase
        end else if (io_rd_stb) begin
            unique case (kind)
                FK_IRQ:    st_d.rd_data = irq_status;
                FK_SWA:    st_d.rd_data = sw_bank_a;
                FK_SWB:    st_d.rd_data = sw_bank_b;
                FK_DEVICE: begin
                    st_d.rd_stb  = 1'b1;
                    st_d.sel     = hit;
                    st_d.func    = func_code;
                    st_d.wdata   = acc_in;
                    st_d.rd_data = any_hit ? sel_rdata : FILL;
                end
                default:   st_d.rd_data = FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.rd_data;
    assign init_pulse = st_q.init;
    assign cur_dev    = st_q.cur_dev;
    assign dev_sel    = st_q.sel;
    assign dev_rd_stb = st_q.rd_stb;
    assign dev_wr_stb = st_q.wr_stb;
    assign dev_func   = st_q.func;
    assign dev_wdata  = st_q.wdata;

endmodule

// File: rtl/iofn_selector_chk.sv
module iofn_selector_chk #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_DEV = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               io_rd_stb,
    input logic               io_wr_stb,
    input logic [DATA_W-1:0]  func_code,
    input logic [DATA_W-1:0]  acc_in,
    input logic               init_pulse,
    input logic [DATA_W-1:0]  cur_dev,
    input logic [NUM_DEV-1:0] dev_sel,
    input logic               dev_rd_stb,
    input logic               dev_wr_stb
);

    assert_init_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> !init_pulse);

    assert_init_clears_dev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |-> (cur_dev == '0));

    assert_setdev_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_stb && func_code == DATA_W'(1)) |=> (cur_dev == $past(acc_in)));

    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    assert_builtin_not_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_rd_stb || io_wr_stb) && func_code < DATA_W'(5)) |=> (!dev_rd_stb && !dev_wr_stb && dev_sel == '0));

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd_stb && dev_wr_stb));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd_stb && !io_wr_stb) |=> (!dev_rd_stb && !dev_wr_stb && dev_sel == '0));

endmodule

bind iofn_selector iofn_selector_chk #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_rd_stb  (io_rd_stb),
    .io_wr_stb  (io_wr_stb),
    .func_code  (func_code),
    .acc_in     (acc_in),
    .init_pulse (init_pulse),
    .cur_dev    (cur_dev),
    .dev_sel    (dev_sel),
    .dev_rd_stb (dev_rd_stb),
    .dev_wr_stb (dev_wr_stb)
);

// File: tb/iofn_selector_bench.sv
`timescale 1ns/1ps
module iofn_selector_bench;

    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NUM_DEV = 4;
    localparam int unsigned NVEC    = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_rd_stb = 1'b0;
    logic io_wr_stb = 1'b0;
    logic [7:0] func_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] irq_status = 8'h5A;
    logic [7:0] sw_bank_a = 8'hC3;
    logic [7:0] sw_bank_b = 8'h3C;
    logic [31:0] dev_rdata = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    logic [7:0] rd_data, cur_dev, dev_func, dev_wdata;
    logic [3:0] dev_sel;
    logic init_pulse, dev_rd_stb, dev_wr_stb;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    iofn_selector #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV)) u_iofn_selector (
        .clk(clk), .rst_n(rst_n), .io_rd_stb(io_rd_stb), .io_wr_stb(io_wr_stb),
        .func_code(func_code), .acc_in(acc_in), .irq_status(irq_status),
        .sw_bank_a(sw_bank_a), .sw_bank_b(sw_bank_b), .dev_rdata(dev_rdata),
        .rd_data(rd_data), .init_pulse(init_pulse), .cur_dev(cur_dev),
        .dev_sel(dev_sel), .dev_rd_stb(dev_rd_stb), .dev_wr_stb(dev_wr_stb),
        .dev_func(dev_func), .dev_wdata(dev_wdata)
    );

    // {wr, func, acc, exp rd_data, exp cur_dev, exp dev_sel, exp any strobe, exp init}
    localparam logic [38:0] VECS [NVEC] = '{
        {1'b0, 8'h02, 8'h00, 8'h5A, 8'h00, 4'b0000, 1'b0, 1'b0}, // R2
        {1'b0, 8'h03, 8'h00, 8'hC3, 8'h00, 4'b0000, 1'b0, 1'b0}, // R3
        {1'b0, 8'h04, 8'h00, 8'h3C, 8'h00, 4'b0000, 1'b0, 1'b0}, // R3
        {1'b1, 8'h01, 8'h02, 8'h3C, 8'h02, 4'b0000, 1'b0, 1'b0}, // R5
        {1'b1, 8'h07, 8'h99, 8'h3C, 8'h02, 4'b0100, 1'b1, 1'b0}, // R6
        {1'b0, 8'h09, 8'h00, 8'hA2, 8'h02, 4'b0100, 1'b1, 1'b0}, // R7
        {1'b1, 8'h01, 8'h03, 8'hA2, 8'h03, 4'b0000, 1'b0, 1'b0}, // R5
        {1'b0, 8'h05, 8'h00, 8'hA3, 8'h03, 4'b1000, 1'b1, 1'b0}, // R7
        {1'b1, 8'h01, 8'h40, 8'hA3, 8'h40, 4'b0000, 1'b0, 1'b0}, // R5
        {1'b0, 8'h06, 8'h00, 8'hFF, 8'h40, 4'b0000, 1'b1, 1'b0}, // R7 no device
        {1'b0, 8'h00, 8'h00, 8'hFF, 8'h40, 4'b0000, 1'b0, 1'b0}, // R9
        {1'b1, 8'h00, 8'h00, 8'hFF, 8'h00, 4'b0000, 1'b0, 1'b1}, // R4
        {1'b0, 8'h0A, 8'h00, 8'hA0, 8'h00, 4'b0001, 1'b1, 1'b0}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one instruction at the falling edge, sample after the next rising edge
    task automatic issue(input logic rd, input logic wr, input logic [7:0] fc, input logic [7:0] acc);
        @(negedge clk);
        io_rd_stb = rd;
        io_wr_stb = wr;
        func_code = fc;
        acc_in    = acc;
        @(negedge clk);
        io_rd_stb = 1'b0;
        io_wr_stb = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 rd_data", 32'(rd_data), 32'h0);
        check("R1 cur_dev", 32'(cur_dev), 32'h0);
        check("R1 strobes", {29'h0, init_pulse, dev_rd_stb, dev_wr_stb}, 32'h0);
        check("R1 dev_sel", 32'(dev_sel), 32'h0);
        check("R1 dev_func", 32'(dev_func), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [38:0] v;
            v = VECS[i];
            issue(!v[38], v[38], v[37:30], v[29:22]);
            check($sformatf("vec%0d rd_data R2 R3 R7 R9", i), 32'(rd_data), 32'(v[21:14]));
            check($sformatf("vec%0d cur_dev R4 R5", i), 32'(cur_dev), 32'(v[13:6]));
            check($sformatf("vec%0d dev_sel R6 R7 R8", i), 32'(dev_sel), 32'(v[5:2]));
            check($sformatf("vec%0d strobe R8", i), 32'(dev_rd_stb | dev_wr_stb), 32'(v[1]));
            check($sformatf("vec%0d init R4", i), 32'(init_pulse), 32'(v[0]));
        end

        // R4: pulse lasts one clock
        issue(1'b0, 1'b1, 8'h01, 8'h03);
        issue(1'b0, 1'b1, 8'h00, 8'h77);
        check("R4 init high", 32'(init_pulse), 32'h1);
        check("R4 cur_dev cleared", 32'(cur_dev), 32'h0);
        @(negedge clk);
        check("R4 init one clock", 32'(init_pulse), 32'h0);

        // R6: forwarded code and data
        issue(1'b0, 1'b1, 8'h01, 8'h01);
        issue(1'b0, 1'b1, 8'h33, 8'h5E);
        check("R6 dev_wr_stb", {30'h0, dev_wr_stb, dev_rd_stb}, 32'h2);
        check("R6 dev_func", 32'(dev_func), 32'h33);
        check("R6 dev_wdata", 32'(dev_wdata), 32'h5E);
        check("R6 dev_sel", 32'(dev_sel), 32'h2);
        // R11: idle clock
        @(negedge clk);
        check("R11 idle strobes", {30'h0, dev_wr_stb, dev_rd_stb}, 32'h0);
        check("R11 idle sel", 32'(dev_sel), 32'h0);
        check("R11 cur_dev held", 32'(cur_dev), 32'h1);

        // R8: output to built-in input code has no device effect
        issue(1'b0, 1'b1, 8'h03, 8'h11);
        check("R8 out code 03 strobes", {30'h0, dev_wr_stb, dev_rd_stb}, 32'h0);
        check("R8 out code 03 cur_dev", 32'(cur_dev), 32'h1);

        // R10: both strobes in one clock
        issue(1'b0, 1'b0, 8'h00, 8'h00);
        @(negedge clk);
        io_rd_stb = 1'b1; io_wr_stb = 1'b1; func_code = 8'h02; acc_in = 8'h00;
        @(negedge clk);
        io_rd_stb = 1'b0; io_wr_stb = 1'b0;
        check("R10 rd_data unchanged", 32'(rd_data), 32'hA0);
        check("R10 no strobe", {30'h0, dev_wr_stb, dev_rd_stb}, 32'h0);

        // R1: reset in the middle of a run
        issue(1'b0, 1'b1, 8'h01, 8'h02);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset cur_dev", 32'(cur_dev), 32'h0);
        check("R1 mid reset rd_data", 32'(rd_data), 32'h0);
        rst_n = 1'b1;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule